// File: doc/BRIEF.md
# Parallel flash programming sequencer

This block runs the parallel programming interface of a small flash microcontroller. It drives the digital controls for the target's supply switch, its three reset levels (0 V, a 5 V level built by pulse-width modulating the 12 V switch, and a static 12 V), the program strobe, the address clock, three mode pins and an 8-bit data bus. It reads the image to program from a synchronous RAM port, and it writes the image it reads back to that same port.

A host issues one start pulse with an operation code. The block then powers the target, selects the mode, carries out the operation, powers the target down, and pulses `done` with the verify status. There are four operations: chip erase, code write followed by a verify pass, code read, and lock-bit programming. The target's memory holds `PAGES` pages of `PAGE_BYTES` bytes. The target advances its internal address on each rising edge of the address clock, and it starts from address zero at power-up.

Top module: `pflash_prog_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `verify_err`, `vcc_en`, `hv_sw`, `xtal` and `tgt_oe` are 0, and `prog_n` is 1.
- R2: A `start` pulse while idle raises `busy` on the next cycle. `busy` stays high until the operation ends. `done` is a one-cycle pulse in the cycle after `busy` falls back to 0. A `start` while busy is ignored. Operation codes are 0 erase, 1 write, 2 read and 3 lock.
- R3: The mode pins, given as {M2,M1,M0}, are 3'b110 for code write, 3'b100 for code read and verify, 3'b001 for chip erase, 3'b111 for lock bit 1 and 3'b011 for lock bit 2.
- R4: At the 5 V level, `hv_sw` repeats a pattern of `PWM_ON` cycles high followed by `PWM_PERIOD-PWM_ON` cycles low. At 12 V it is held high, and at 0 V it is held low.
- R5: After every change of reset level, including the power-up change to 5 V, at least `SETTLE_CYC` cycles pass before the next strobe or address clock.
- R6: Code write programs every address in turn from RAM. The reset level goes to 12 V only once, before the first byte.
- R7: Each program strobe in a write is low for `PULSE_CYC` to `PULSE_CYC+2` cycles. At least `PROG_WAIT_CYC` cycles then pass before the address clock pulse. `xtal` is never high while `prog_n` is low.
- R8: Verify reads back every address at 5 V and compares it with RAM. The first mismatch stops the pass with no further address clocks and sets `verify_err`.
- R9: Chip erase holds `prog_n` low for at least `ERASE_CYC` cycles with the reset level at 12 V.
- R10: Code read writes each target byte to RAM at the same address, in ascending order.
- R11: Lock write programs each bit set in `lock_en` (bit 0 first) in its own power cycle. With `lock_en` = 0 it powers nothing and still pulses `done`.
- R12: Power-off lowers `xtal`, then sets the reset level to 0 V and waits `SETTLE_CYC`, then clears `vcc_en`. `hv_sw` is never high while `vcc_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse; accepted when idle |
| op | input | 2 | Operation code (0 erase, 1 write, 2 read, 3 lock) |
| lock_en | input | 2 | Lock bits to program (bit 0 = lock bit 1) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end pulse |
| verify_err | output | 1 | Verify mismatch found in the last write |
| ram_addr | output | log2(PAGES*PAGE_BYTES) | RAM address |
| ram_rdata | input | 8 | RAM read data, one cycle after address |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 8 | RAM write data |
| vcc_en | output | 1 | Target supply switch |
| hv_sw | output | 1 | 12 V reset switch (PWM for 5 V) |
| prog_n | output | 1 | Program strobe, active low |
| xtal | output | 1 | Address advance clock |
| mode | output | 3 | Mode pins {M2,M1,M0} |
| tgt_dout | output | 8 | Data driven to the target |
| tgt_oe | output | 1 | Drive enable for `tgt_dout` |
| tgt_din | input | 8 | Data read from the target |

## Verification
The hardest case to reach is a verify failure part way through a pass. A correct write always reads back clean, so a port-level run never produces a mismatch on its own. The bench's behavioural target therefore has a fault switch that inverts the read-back value at one chosen address. The bench counts the address clocks seen in read mode and checks that the pass stops exactly at that address with the error flag set. Lock programming with one bit, both bits or no bits is told apart by counting supply power-ups.

// File: rtl/pfp_pkg.sv
package pfp_pkg;
  typedef enum logic [1:0] {OP_ERASE = 2'd0, OP_WRITE = 2'd1, OP_READ = 2'd2, OP_LOCK = 2'd3} op_e;
  typedef enum logic [1:0] {LVL_0V = 2'd0, LVL_5V = 2'd1, LVL_12V = 2'd2} lvl_e;
  // mode pins ordered {M2,M1,M0}
  localparam logic [2:0] MODE_WRITE = 3'b110;
  localparam logic [2:0] MODE_READ  = 3'b100;
  localparam logic [2:0] MODE_ERASE = 3'b001;
  localparam logic [2:0] MODE_LOCK1 = 3'b111;
  localparam logic [2:0] MODE_LOCK2 = 3'b011;
endpackage

// File: rtl/pfp_timer.sv
module pfp_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (load) cnt_q <= val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // R5: every wait must last at least one cycle
  a_r5_load_nonzero: assert property (@(posedge clk) disable iff (rst) load |-> (val != '0));
endmodule

// File: rtl/pfp_rst_level.sv
module pfp_rst_level #(
  parameter int PWM_ON     = 30,
  parameter int PWM_PERIOD = 2200
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] lvl,
  output logic       hv_sw
);
  import pfp_pkg::*;
  localparam int CW = $clog2(PWM_PERIOD + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [1:0]    lvl_q;

  always_comb begin
    if (lvl != lvl_q) cnt_d = '0;
    else if (cnt_q == CW'(PWM_PERIOD - 1)) cnt_d = '0;
    else cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      lvl_q <= LVL_0V;
      hv_sw <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      lvl_q <= lvl;
      case (lvl)
        LVL_12V: hv_sw <= 1'b1;
        LVL_5V:  hv_sw <= (cnt_d < CW'(PWM_ON));
        default: hv_sw <= 1'b0;
      endcase
    end
  end

  // R4: phase counter stays inside one period
  a_r4_cnt_range: assert property (@(posedge clk) disable iff (rst) cnt_q < CW'(PWM_PERIOD));
  // R4: a steady 0 V request keeps the switch open
  a_r4_zero_low: assert property (@(posedge clk) disable iff (rst)
    (lvl == LVL_0V && lvl_q == LVL_0V) |=> !hv_sw);
endmodule

// File: rtl/pflash_prog_seq.sv
module pflash_prog_seq #(
  parameter int PAGES         = 8,
  parameter int PAGE_BYTES    = 256,
  parameter int SETTLE_CYC    = 2000000,
  parameter int PULSE_CYC     = 200,
  parameter int PROG_WAIT_CYC = 400000,
  parameter int ERASE_CYC     = 2000000,
  parameter int PWM_ON        = 30,
  parameter int PWM_PERIOD    = 2200,
  localparam int AW = $clog2(PAGES * PAGE_BYTES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [1:0]    op,
  input  logic [1:0]    lock_en,
  output logic          busy,
  output logic          done,
  output logic          verify_err,
  output logic [AW-1:0] ram_addr,
  input  logic [7:0]    ram_rdata,
  output logic          ram_we,
  output logic [7:0]    ram_wdata,
  output logic          vcc_en,
  output logic          hv_sw,
  output logic          prog_n,
  output logic          xtal,
  output logic [2:0]    mode,
  output logic [7:0]    tgt_dout,
  output logic          tgt_oe,
  input  logic [7:0]    tgt_din
);
  import pfp_pkg::*;

  localparam int MAX_A = (SETTLE_CYC > ERASE_CYC) ? SETTLE_CYC : ERASE_CYC;
  localparam int MAX_B = (PROG_WAIT_CYC > PULSE_CYC) ? PROG_WAIT_CYC : PULSE_CYC;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TW    = $clog2(MAX_C + 1);
  localparam logic [AW-1:0] LAST_ADDR = AW'(PAGES * PAGE_BYTES - 1);

  typedef enum logic [4:0] {
    S_IDLE, S_PWR, S_WAIT, S_MODE, S_FETCH, S_WR_DRIVE, S_WR_PULSE, S_WR_REL,
    S_XT_HI, S_XT_LO, S_VF_BEGIN, S_VF_CMP, S_RD_SAMPLE, S_ER_PULSE, S_ER_REL,
    S_LK_PULSE, S_LK_REL, S_POFF, S_OFF, S_DONE
  } state_e;

  state_e        state, ret_q;
  op_e           op_q;
  lvl_e          lvl_q;
  logic [1:0]    lk_q;
  logic          first_q, vf_q;
  logic [AW-1:0] addr_q;
  logic          tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val;

  pfp_timer #(.W(TW)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .val(tmr_val), .zero(tmr_zero)
  );

  pfp_rst_level #(.PWM_ON(PWM_ON), .PWM_PERIOD(PWM_PERIOD)) u_rst_level (
    .clk(clk), .rst(rst), .lvl(lvl_q), .hv_sw(hv_sw)
  );

  // wait length chosen by the state that starts it
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state)
      S_PWR, S_VF_BEGIN, S_POFF: begin tmr_load = 1'b1; tmr_val = TW'(SETTLE_CYC); end
      S_MODE: begin
        tmr_load = (op_q == OP_ERASE) || (op_q == OP_LOCK);
        tmr_val  = TW'(SETTLE_CYC);
      end
      S_WR_DRIVE: begin tmr_load = first_q; tmr_val = TW'(SETTLE_CYC); end
      S_WR_PULSE, S_LK_PULSE: begin tmr_load = 1'b1; tmr_val = TW'(PULSE_CYC); end
      S_WR_REL, S_LK_REL: begin tmr_load = 1'b1; tmr_val = TW'(PROG_WAIT_CYC); end
      S_ER_PULSE: begin tmr_load = 1'b1; tmr_val = TW'(ERASE_CYC); end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      ret_q      <= S_IDLE;
      op_q       <= OP_ERASE;
      lvl_q      <= LVL_0V;
      lk_q       <= '0;
      first_q    <= 1'b0;
      vf_q       <= 1'b0;
      addr_q     <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      verify_err <= 1'b0;
      ram_we     <= 1'b0;
      ram_wdata  <= '0;
      vcc_en     <= 1'b0;
      prog_n     <= 1'b1;
      xtal       <= 1'b0;
      mode       <= '0;
      tgt_dout   <= '0;
      tgt_oe     <= 1'b0;
    end else begin
      done   <= 1'b0;
      ram_we <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          busy       <= 1'b1;
          verify_err <= 1'b0;
          op_q       <= op_e'(op);
          lk_q       <= lock_en;
          addr_q     <= '0;
          first_q    <= 1'b1;
          vf_q       <= 1'b0;
          state      <= (op_e'(op) == OP_LOCK && lock_en == 2'b00) ? S_DONE : S_PWR;
        end
        S_PWR: begin
          vcc_en <= 1'b1;
          prog_n <= 1'b1;
          lvl_q  <= LVL_5V;
          ret_q  <= S_MODE;
          state  <= S_WAIT;
        end
        S_WAIT: if (tmr_zero) state <= ret_q;
        S_MODE: begin
          case (op_q)
            OP_ERASE: begin
              mode <= MODE_ERASE; lvl_q <= LVL_12V; ret_q <= S_ER_PULSE; state <= S_WAIT;
            end
            OP_WRITE: begin mode <= MODE_WRITE; tgt_oe <= 1'b1; state <= S_FETCH; end
            OP_READ:  begin mode <= MODE_READ;  tgt_oe <= 1'b0; state <= S_FETCH; end
            default: begin
              mode  <= lk_q[0] ? MODE_LOCK1 : MODE_LOCK2;
              lvl_q <= LVL_12V;
              ret_q <= S_LK_PULSE;
              state <= S_WAIT;
            end
          endcase
        end
        S_FETCH: state <= (op_q == OP_READ) ? S_RD_SAMPLE : (vf_q ? S_VF_CMP : S_WR_DRIVE);
        S_WR_DRIVE: begin
          tgt_dout <= ram_rdata;
          if (first_q) begin
            first_q <= 1'b0;
            lvl_q   <= LVL_12V;
            ret_q   <= S_WR_PULSE;
            state   <= S_WAIT;
          end else begin
            state <= S_WR_PULSE;
          end
        end
        S_WR_PULSE: begin prog_n <= 1'b0; ret_q <= S_WR_REL; state <= S_WAIT; end
        S_WR_REL:   begin prog_n <= 1'b1; ret_q <= S_XT_HI;  state <= S_WAIT; end
        S_XT_HI:    begin xtal <= 1'b1; state <= S_XT_LO; end
        S_XT_LO: begin
          xtal   <= 1'b0;
          addr_q <= addr_q + 1'b1;
          if (addr_q == LAST_ADDR)
            state <= (op_q == OP_WRITE && !vf_q) ? S_VF_BEGIN : S_POFF;
          else
            state <= S_FETCH;
        end
        S_VF_BEGIN: begin
          vf_q   <= 1'b1;
          tgt_oe <= 1'b0;
          addr_q <= '0;
          lvl_q  <= LVL_5V;
          mode   <= MODE_READ;
          ret_q  <= S_FETCH;
          state  <= S_WAIT;
        end
        S_VF_CMP: begin
          if (tgt_din != ram_rdata) begin
            verify_err <= 1'b1;
            state      <= S_POFF;
          end else begin
            state <= S_XT_HI;
          end
        end
        S_RD_SAMPLE: begin ram_we <= 1'b1; ram_wdata <= tgt_din; state <= S_XT_HI; end
        S_ER_PULSE:  begin prog_n <= 1'b0; ret_q <= S_ER_REL; state <= S_WAIT; end
        S_ER_REL:    begin prog_n <= 1'b1; state <= S_POFF; end
        S_LK_PULSE:  begin prog_n <= 1'b0; ret_q <= S_LK_REL; state <= S_WAIT; end
        S_LK_REL: begin
          prog_n <= 1'b1;
          lk_q   <= lk_q[0] ? {lk_q[1], 1'b0} : 2'b00;
          ret_q  <= S_POFF;
          state  <= S_WAIT;
        end
        S_POFF: begin
          xtal   <= 1'b0;
          tgt_oe <= 1'b0;
          lvl_q  <= LVL_0V;
          ret_q  <= S_OFF;
          state  <= S_WAIT;
        end
        S_OFF: begin
          vcc_en <= 1'b0;
          mode   <= '0;
          prog_n <= 1'b1;
          state  <= (op_q == OP_LOCK && lk_q != 2'b00) ? S_PWR : S_DONE;
        end
        S_DONE: begin busy <= 1'b0; done <= 1'b1; state <= S_IDLE; end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign ram_addr = addr_q;

  // R12: reset switch only with supply on
  a_r12_hv_needs_vcc: assert property (@(posedge clk) disable iff (rst) hv_sw |-> vcc_en);
  // R12: supply drops only after xtal and reset are low
  a_r12_off_order: assert property (@(posedge clk) disable iff (rst)
    $fell(vcc_en) |-> (!xtal && !hv_sw));
  // R7: no address clock during a program strobe
  a_r7_xtal_prog: assert property (@(posedge clk) disable iff (rst) xtal |-> prog_n);
  // R7: strobe only with supply on
  a_r7_prog_vcc: assert property (@(posedge clk) disable iff (rst) !prog_n |-> vcc_en);
  // R2: done is a single-cycle pulse outside busy
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  a_r2_done_idle: assert property (@(posedge clk) disable iff (rst) done |-> !busy);
  // R8: error can only appear within an operation
  a_r8_err_in_op: assert property (@(posedge clk) disable iff (rst) $rose(verify_err) |-> busy);
endmodule

// File: tb/test_pflash_prog_seq.sv
`timescale 1ns/1ps
module test_pflash_prog_seq;
  localparam int PG = 4, PB = 4, SZ = PG * PB, AW = 4;
  localparam int ST = 20, PU = 4, PW = 10, ER = 40, PON = 3, PPER = 12;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, start, busy, done, verify_err, ram_we, vcc_en, hv_sw, prog_n, xtal, tgt_oe;
  logic [1:0] op_i, lock_i;
  logic [AW-1:0] ram_addr;
  logic [7:0] ram_rdata, ram_wdata, tgt_dout, tgt_din;
  logic [2:0] mode;

  pflash_prog_seq #(.PAGES(PG), .PAGE_BYTES(PB), .SETTLE_CYC(ST), .PULSE_CYC(PU),
    .PROG_WAIT_CYC(PW), .ERASE_CYC(ER), .PWM_ON(PON), .PWM_PERIOD(PPER)) i_pflash_prog_seq (
    .clk(clk), .rst(rst), .start(start), .op(op_i), .lock_en(lock_i), .busy(busy),
    .done(done), .verify_err(verify_err), .ram_addr(ram_addr), .ram_rdata(ram_rdata),
    .ram_we(ram_we), .ram_wdata(ram_wdata), .vcc_en(vcc_en), .hv_sw(hv_sw),
    .prog_n(prog_n), .xtal(xtal), .mode(mode), .tgt_dout(tgt_dout), .tgt_oe(tgt_oe),
    .tgt_din(tgt_din));

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bench RAM, synchronous read
  logic [7:0] bram [SZ];
  always @(posedge clk) begin
    if (ram_we) bram[ram_addr] <= ram_wdata;
    ram_rdata <= bram[ram_addr];
  end

  // behavioural target and monitor
  logic [7:0] tmem [SZ];
  int taddr = 0, corrupt_a = -1;
  assign tgt_din = (taddr == corrupt_a) ? ~tmem[taddr] : tmem[taddr];

  logic p_prog = 1, p_xtal = 0, p_vcc = 0, p_hv = 0;
  int hv_run = 0, lo_run = 0, low_len = 0, since_vcc = 0, since_prog = 0;
  int hv12_entries = 0, pwr_cycles = 0, vf_xtal = 0, wr_pulses = 0, done_cnt = 0;
  int bad_pulse = 0, bad_wait = 0, bad_off = 0, min_gap = 1000000, erase_low = 0;
  int pwm_hi_ok = 0, pwm_lo_ok = 0;
  bit first_act = 0, lk1 = 0, lk2 = 0;
  logic [AW+7:0] expq [$];

  always @(negedge clk) begin
    if (!rst) begin
      if (done) done_cnt++;
      if (!hv_sw && p_hv && hv_run == PON) pwm_hi_ok++;
      if (hv_sw && !p_hv && vcc_en && lo_run == PPER - PON) pwm_lo_ok++;
      if (hv_sw) begin hv_run++; lo_run = 0; end else begin hv_run = 0; lo_run++; end
      if (hv_sw && hv_run == PON + 1) hv12_entries++;
      since_vcc++;
      since_prog++;
      if (vcc_en && !p_vcc) begin taddr = 0; since_vcc = 0; first_act = 1; pwr_cycles++; end
      if (!vcc_en && p_vcc && (xtal || lo_run < ST)) bad_off++;
      if (first_act && ((!prog_n && p_prog) || (xtal && !p_xtal))) begin
        if (since_vcc < min_gap) min_gap = since_vcc;
        first_act = 0;
      end
      if (!prog_n) low_len++;
      if (prog_n && !p_prog) begin
        if (hv_run > PON) begin
          if (mode == 3'b110) begin
            tmem[taddr] = tgt_dout;
            wr_pulses++;
            if (low_len < PU || low_len > PU + 2) bad_pulse++;
          end
          if (mode == 3'b001) begin
            erase_low = low_len;
            if (low_len >= ER) for (int i = 0; i < SZ; i++) tmem[i] = 8'hFF;
          end
          if (mode == 3'b111) lk1 = 1;
          if (mode == 3'b011) lk2 = 1;
        end
        low_len = 0;
        since_prog = 0;
      end
      if (xtal && !p_xtal) begin
        if (mode == 3'b110 && since_prog < PW) bad_wait++;
        if (mode == 3'b100 && tgt_oe == 1'b0 && busy) vf_xtal++;
        taddr = (taddr + 1) % SZ;
      end
      if (ram_we) begin
        if (expq.size() == 0) chk(0, "R10 unexpected RAM write", int'(ram_addr), -1);
        else begin
          logic [AW+7:0] e;
          e = expq.pop_front();
          chk({ram_addr, ram_wdata} == e, "R10 read byte", int'({ram_addr, ram_wdata}), int'(e));
        end
      end
      p_prog = prog_n; p_xtal = xtal; p_vcc = vcc_en; p_hv = hv_sw;
    end
  end

  task automatic push_read_expect();
    for (int i = 0; i < SZ; i++) expq.push_back({AW'(i), tmem[i]});
  endtask

  task automatic run_op(input logic [1:0] o, input logic [1:0] lk);
    @(negedge clk);
    start = 1'b1; op_i = o; lock_i = lk;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    while (!done) @(negedge clk);
    chk(busy == 1'b0, "R2 busy low with done", int'(busy), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int pc, dc, mism;
    rst = 1'b1; start = 1'b0; op_i = 2'd0; lock_i = 2'd0;
    for (int i = 0; i < SZ; i++) begin bram[i] = 8'(i * 29 + 7); tmem[i] = 8'(i * 37 + 5); end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !verify_err, "R1 status idle", int'({busy, done, verify_err}), 0);
    chk(!vcc_en && !hv_sw && !xtal && !tgt_oe, "R1 controls off", int'({vcc_en, hv_sw, xtal, tgt_oe}), 0);
    chk(prog_n == 1'b1, "R1 prog_n high", int'(prog_n), 1);

    // R9, R3: chip erase
    pc = pwr_cycles;
    run_op(2'd0, 2'd0);
    mism = 0;
    for (int i = 0; i < SZ; i++) if (tmem[i] != 8'hFF) mism++;
    chk(mism == 0, "R9 erase cleared target", mism, 0);
    chk(erase_low >= ER, "R9 erase strobe width", erase_low, ER);
    chk(pwr_cycles == pc + 1, "R3 erase one power cycle", pwr_cycles - pc, 1);

    // R6, R7, R8, R5: write with verify
    hv12_entries = 0; vf_xtal = 0; wr_pulses = 0;
    run_op(2'd1, 2'd0);
    mism = 0;
    for (int i = 0; i < SZ; i++) if (tmem[i] != bram[i]) mism++;
    chk(mism == 0, "R6 target matches RAM", mism, 0);
    chk(wr_pulses == SZ, "R6 one strobe per byte", wr_pulses, SZ);
    chk(hv12_entries == 1, "R6 12V raised once", hv12_entries, 1);
    chk(bad_pulse == 0, "R7 strobe width", bad_pulse, 0);
    chk(bad_wait == 0, "R7 wait before xtal", bad_wait, 0);
    chk(verify_err == 1'b0, "R8 clean verify", int'(verify_err), 0);
    chk(vf_xtal == SZ, "R8 verify visits all", vf_xtal, SZ);
    chk(min_gap >= ST, "R5 settle before activity", min_gap, ST);
    chk(pwm_hi_ok > 0, "R4 5V high phase", pwm_hi_ok, 1);
    chk(pwm_lo_ok > 0, "R4 5V low phase", pwm_lo_ok, 1);

    // R8: verify mismatch stops the pass
    corrupt_a = 5; vf_xtal = 0;
    run_op(2'd1, 2'd0);
    chk(verify_err == 1'b1, "R8 mismatch flagged", int'(verify_err), 1);
    chk(vf_xtal == 5, "R8 pass stops at mismatch", vf_xtal, 5);
    corrupt_a = -1;

    // R10: code read through scoreboard
    for (int i = 0; i < SZ; i++) begin tmem[i] = 8'(i * 11 + 3); bram[i] = 8'h00; end
    push_read_expect();
    run_op(2'd2, 2'd0);
    chk(expq.size() == 0, "R10 all bytes read", expq.size(), 0);
    mism = 0;
    for (int i = 0; i < SZ; i++) if (bram[i] != tmem[i]) mism++;
    chk(mism == 0, "R10 RAM holds image", mism, 0);

    // R11: lock bits
    lk1 = 0; lk2 = 0; pc = pwr_cycles;
    run_op(2'd3, 2'b11);
    chk(lk1 && lk2, "R11 both lock bits", int'({lk1, lk2}), 3);
    chk(pwr_cycles == pc + 2, "R11 two power cycles", pwr_cycles - pc, 2);
    lk1 = 0; lk2 = 0; pc = pwr_cycles;
    run_op(2'd3, 2'b10);
    chk(!lk1 && lk2, "R11 only lock bit 2", int'({lk1, lk2}), 1);
    chk(pwr_cycles == pc + 1, "R11 one power cycle", pwr_cycles - pc, 1);
    pc = pwr_cycles; dc = done_cnt;
    run_op(2'd3, 2'b00);
    chk(pwr_cycles == pc, "R11 no lock bits no power", pwr_cycles - pc, 0);

    // R2: start while busy is ignored
    @(negedge clk);
    start = 1'b1; op_i = 2'd0;
    @(negedge clk);
    start = 1'b0;
    repeat (30) @(negedge clk);
    pc = pwr_cycles; dc = done_cnt;
    start = 1'b1; op_i = 2'd2;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    repeat (60) @(negedge clk);
    chk(pwr_cycles == pc, "R2 busy start ignored", pwr_cycles - pc, 0);
    chk(done_cnt == dc + 1, "R2 single done", done_cnt - dc, 1);

    // R12: power-off order over all operations
    chk(bad_off == 0, "R12 power-off order", bad_off, 0);
    chk(!vcc_en && !hv_sw, "R12 idle off", int'({vcc_en, hv_sw}), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule